// File: doc/BRIEF.md
# Strobe-Framed Serial Voice Port

This block carries one 8-bit voice sample per frame in each direction between a parallel codec side and a serial line. The window on the line is set by a strobe input: the serial output is enabled only while the strobe is high, received bits are captured only inside that window, and one transmit sample is latched when each window opens.

The port has two clocking modes. In synchronous mode the line runs on an external bit clock. The sample moves between the parallel side and the line in the same frame. In asynchronous mode the port makes its own bit clock by dividing a master clock by 16 or 32, and restarts that divider when each window opens. Data in asynchronous mode is re-timed through one frame of storage in each direction.

A 4-bit path selector decides whether the parallel transmit sample is sent at all. When it is not sent, a fixed quiet code fills the window. All line inputs are brought into the system clock domain through a synchronizer, and line events are taken from edges seen on the synchronized signals.

Top module: `strobe_voice_port`

## Requirements
- R1: While the synchronized strobe is low, `dout_oe_o` is 0 and `dout_o` is 0. Throughout an open window, `dout_oe_o` is 1.
- R2: In synchronous mode (`mode_i`=0), `din_i` is shifted in MSB first on each falling edge of `bclk_i` inside the window. After the 8th capture, `rx_data_o` holds that same window's sample.
- R3: In synchronous mode, the sample latched when the window opens is driven MSB first in the same window. The first bit appears at window open, and `dout_o` advances one bit on each rising bit-clock edge that follows a capture.
- R4: The window carries the quiet code 8'hFF when the path code is 4'b0000, when the path code has bit 3 set, or when `tx_valid_i` is low at window open. Any other path code sends `tx_data_i`.
- R5: A window longer than 8 bit clocks carries only 8 bits. Received bits after the 8th are ignored, and `dout_o` is 1 for every bit position after the 8th.
- R6: A window that ends with fewer than 8 captured bits produces no `rx_valid_o`. It produces a one-cycle `err_o` pulse shortly after the strobe falls.
- R7: In asynchronous mode (`mode_i`=1), one bit lasts 16 master-clock rising edges when `rate_i` is 2'b01, and 32 edges for any other `rate_i` value. Bit timing restarts when each window opens.
- R8: In asynchronous mode, the sample driven in window N is the effective transmit sample latched in window N-1. The sample reported in window N is the one captured in the last complete window before it. Both stores hold 8'hFF after reset.
- R9: In asynchronous mode, activity on `bclk_i` has no effect on the serial data.
- R10: `rx_valid_o` pulses for exactly one system clock, once per complete window. `rx_data_o` is read while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = external bit clock, 1 = internal bit clock |
| rate_i | input | 2 | Internal bit-rate select (2'b01 fast, others slow) |
| bclk_i | input | 1 | External bit clock |
| mclk_i | input | 1 | Master clock for the internal divider |
| strobe_i | input | 1 | Window strobe, active high |
| din_i | input | 1 | Serial receive data |
| dout_o | output | 1 | Serial transmit data |
| dout_oe_o | output | 1 | Tri-state enable for `dout_o` |
| tx_path_i | input | 4 | Transmit path selector |
| tx_data_i | input | 8 | Parallel transmit sample |
| tx_valid_i | input | 1 | Transmit sample valid |
| rx_data_o | output | 8 | Parallel receive sample |
| rx_valid_o | output | 1 | One-cycle receive strobe |
| err_o | output | 1 | One-cycle short-window flag |

## Verification
The hardest situation to reach is the asynchronous one-frame pipeline. There, what appears on the line and on `rx_data_o` depends on the previous window, including short windows: those still update the transmit store but leave the receive store untouched. The stimulus runs chains of asynchronous windows at both divide ratios and inserts a short window in the middle of a chain. The external bit clock keeps toggling throughout, and a model of the two stores predicts each window. Synchronous runs mix directed quiet-code, long-window and short-window cases with seeded random samples, path codes and window lengths.

// File: rtl/svp_pkg.sv
package svp_pkg;
  typedef enum logic {
    MODE_SYNC  = 1'b0,
    MODE_ASYNC = 1'b1
  } port_mode_e;

  localparam int PATH_W = 4;

  // path code selects the parallel source only when nonzero with top bit clear
  function automatic logic path_live(input logic [PATH_W-1:0] code);
    return (code != '0) && !code[PATH_W-1];
  endfunction
endpackage

// File: rtl/svp_sync.sv
module svp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/svp_bitgen.sv
module svp_bitgen #(
  parameter int DIV_SLOW = 32,
  parameter int DIV_FAST = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       async_i,
  input  logic [1:0] rate_i,
  input  logic       restart_i,
  input  logic       mclk_rise_i,
  input  logic       bclk_rise_i,
  input  logic       bclk_fall_i,
  output logic       shift_ev_o,
  output logic       sample_ev_o
);
  localparam int PH_W = $clog2(DIV_SLOW);
  localparam logic [PH_W-1:0] SLOW_END = PH_W'(DIV_SLOW - 1);
  localparam logic [PH_W-1:0] FAST_END = PH_W'(DIV_FAST - 1);
  localparam logic [PH_W-1:0] SLOW_MID = PH_W'(DIV_SLOW / 2 - 1);
  localparam logic [PH_W-1:0] FAST_MID = PH_W'(DIV_FAST / 2 - 1);

  logic [PH_W-1:0] ph;
  logic            fast;
  logic [PH_W-1:0] ph_end, ph_mid;
  logic            tick;

  assign fast   = (rate_i == 2'b01);
  assign ph_end = fast ? FAST_END : SLOW_END;
  assign ph_mid = fast ? FAST_MID : SLOW_MID;
  assign tick   = async_i && mclk_rise_i && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph <= '0;
    else if (restart_i)   ph <= '0;
    else if (mclk_rise_i) ph <= (ph >= ph_end) ? '0 : ph + 1'b1;
  end

  // internal edges in async mode, synchronized external edges otherwise
  assign shift_ev_o  = async_i ? (tick && ph == ph_end) : bclk_rise_i;
  assign sample_ev_o = async_i ? (tick && ph == ph_mid) : bclk_fall_i;

  AST_EVENTS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_ev_o && sample_ev_o)); // R7
endmodule

// File: rtl/svp_core.sv
module svp_core #(
  parameter int                  SAMPLE_W = 8,
  parameter logic [SAMPLE_W-1:0] QUIET    = 8'hFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  async_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  active_i,
  input  logic                  shift_ev_i,
  input  logic                  sample_ev_i,
  input  logic                  din_i,
  input  logic [3:0]            path_i,
  input  logic [SAMPLE_W-1:0]   tx_data_i,
  input  logic                  tx_valid_i,
  output logic                  dout_o,
  output logic                  oe_o,
  output logic [SAMPLE_W-1:0]   rx_data_o,
  output logic                  rx_valid_o,
  output logic                  err_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] tx_sh, tx_prev, tx_fresh, tx_view;
  logic [SAMPLE_W-1:0] rx_sh, rx_hold, rx_word;
  logic [CNT_W-1:0]    bit_cnt, tx_idx;
  logic                capture, word_done;

  assign tx_fresh  = (svp_pkg::path_live(path_i) && tx_valid_i) ? tx_data_i : QUIET;
  assign capture   = active_i && !start_i && sample_ev_i && (bit_cnt < FULL);
  assign word_done = capture && (bit_cnt == LAST);
  assign rx_word   = {rx_sh[SAMPLE_W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh   <= QUIET;
      tx_prev <= QUIET;
      bit_cnt <= FULL;
      tx_idx  <= FULL;
      rx_sh   <= '0;
    end else if (start_i) begin
      tx_sh   <= async_i ? tx_prev : tx_fresh;
      tx_prev <= tx_fresh;
      bit_cnt <= '0;
      tx_idx  <= '0;
    end else if (active_i) begin
      if (shift_ev_i) tx_idx <= bit_cnt;
      if (capture) begin
        rx_sh   <= rx_word;
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_hold    <= QUIET;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      rx_valid_o <= word_done;
      err_o      <= stop_i && (bit_cnt != FULL);
      if (word_done) begin
        rx_data_o <= async_i ? rx_hold : rx_word;
        rx_hold   <= rx_word;
      end
    end
  end

  assign tx_view = tx_sh << tx_idx;
  assign oe_o    = active_i && !start_i;
  assign dout_o  = oe_o && ((tx_idx < FULL) ? tx_view[SAMPLE_W-1] : 1'b1);

  AST_RX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R10
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rx_valid_o); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= FULL); // R5
  AST_IDX_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> tx_idx <= bit_cnt); // R3
  AST_QUIET_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !async_i && !svp_pkg::path_live(path_i)) |=> tx_sh == QUIET); // R4
endmodule

// File: rtl/strobe_voice_port.sv
module strobe_voice_port #(
  parameter int                  SAMPLE_W    = 8,
  parameter logic [SAMPLE_W-1:0] QUIET       = 8'hFF,
  parameter int                  SYNC_STAGES = 2,
  parameter int                  DIV_SLOW    = 32,
  parameter int                  DIV_FAST    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic [1:0]          rate_i,
  input  logic                bclk_i,
  input  logic                mclk_i,
  input  logic                strobe_i,
  input  logic                din_i,
  output logic                dout_o,
  output logic                dout_oe_o,
  input  logic [3:0]          tx_path_i,
  input  logic [SAMPLE_W-1:0] tx_data_i,
  input  logic                tx_valid_i,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic                rx_valid_o,
  output logic                err_o
);
  import svp_pkg::*;

  port_mode_e mode;
  logic       is_async;
  logic [3:0] line_q;
  logic       bclk_s, mclk_s, stb_s, din_s;
  logic       bclk_d, mclk_d, stb_d;
  logic       start, stop, shift_ev, sample_ev;

  assign mode     = port_mode_e'(mode_i);
  assign is_async = (mode == MODE_ASYNC);

  svp_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({din_i, strobe_i, mclk_i, bclk_i}),
    .q_o   (line_q)
  );

  assign {din_s, stb_s, mclk_s, bclk_s} = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d <= 1'b0;
      mclk_d <= 1'b0;
      stb_d  <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      mclk_d <= mclk_s;
      stb_d  <= stb_s;
    end
  end

  assign start = stb_s && !stb_d;
  assign stop  = !stb_s && stb_d;

  svp_bitgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_bitgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_i    (is_async),
    .rate_i     (rate_i),
    .restart_i  (start),
    .mclk_rise_i(mclk_s && !mclk_d),
    .bclk_rise_i(bclk_s && !bclk_d),
    .bclk_fall_i(!bclk_s && bclk_d),
    .shift_ev_o (shift_ev),
    .sample_ev_o(sample_ev)
  );

  svp_core #(.SAMPLE_W(SAMPLE_W), .QUIET(QUIET)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_i    (is_async),
    .start_i    (start),
    .stop_i     (stop),
    .active_i   (stb_s),
    .shift_ev_i (shift_ev),
    .sample_ev_i(sample_ev),
    .din_i      (din_s),
    .path_i     (tx_path_i),
    .tx_data_i  (tx_data_i),
    .tx_valid_i (tx_valid_i),
    .dout_o     (dout_o),
    .oe_o       (dout_oe_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .err_o      (err_o)
  );

  AST_OE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> !dout_o); // R1
  AST_OE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> stb_s); // R1
endmodule

// File: tb/strobe_voice_port_test.sv
module strobe_voice_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       bclk = 1'b0;
  logic       mclk = 1'b0;
  logic       strobe = 1'b0;
  logic       din = 1'b0;
  logic [3:0] path = 4'h0;
  logic [7:0] txd = 8'h00;
  logic       txv = 1'b0;
  logic       dout, dout_oe, rx_valid, err;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int vcnt   = 0;
  int ecnt   = 0;
  logic [7:0] vdata = 8'h00;
  logic       bclk_free = 1'b0;
  logic [7:0] prev_tx = 8'hFF;
  logic [7:0] prev_rx = 8'hFF;

  strobe_voice_port uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .rate_i(rate),
    .bclk_i(bclk), .mclk_i(mclk), .strobe_i(strobe), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .tx_path_i(path),
    .tx_data_i(txd), .tx_valid_i(txv), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .err_o(err)
  );

  always #4 clk = ~clk;

  always begin
    repeat (2) @(negedge clk);
    mclk = ~mclk;
  end

  always @(negedge clk) if (bclk_free) bclk = ~bclk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        vcnt  = vcnt + 1;
        vdata = rx_data;
      end
      if (err) ecnt = ecnt + 1;
    end
  end

  function automatic logic [7:0] eff_tx(input logic [7:0] d, input logic v, input logic [3:0] p);
    return (v && p != 4'h0 && !p[3]) ? d : 8'hFF;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    prev_tx = 8'hFF;
    prev_rx = 8'hFF;
  endtask

  task automatic sync_frame(input logic [7:0] td, input logic tv, input logic [3:0] p,
                            input logic [7:0] rd, input int nb);
    int v0 = vcnt;
    int e0 = ecnt;
    logic [7:0] got = 8'h00;
    logic [7:0] expd = eff_tx(td, tv, p);
    logic oe_ok = 1'b1;
    logic tail_ok = 1'b1;
    @(negedge clk);
    txd = td; txv = tv; path = p; bclk = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      bclk = 1'b1;
      if (k == 0) strobe = 1'b1;
      din = (k < 8) ? rd[7-k] : 1'($urandom % 2);
      repeat (8) @(negedge clk);
      bclk = 1'b0;
      repeat (4) @(negedge clk);
      if (!dout_oe) oe_ok = 1'b0;
      if (k < 8) got[7-k] = dout;
      else if (dout !== 1'b1) tail_ok = 1'b0;
      repeat (4) @(negedge clk);
    end
    bclk = 1'b1; strobe = 1'b0;
    repeat (8) @(negedge clk);
    bclk = 1'b0;
    repeat (8) @(negedge clk);
    check(oe_ok, "R1 oe in window", 32'(oe_ok), 1);
    check(!dout_oe && !dout, "R1 idle line", {dout_oe, dout}, 0);
    if (nb >= 8) begin
      check(got == expd, "R3/R4 sync tx sample", got, expd);
      check(vcnt - v0 == 1, "R10 one rx_valid", vcnt - v0, 1);
      check(vdata == rd, "R2 sync rx sample", vdata, rd);
      check(ecnt == e0, "R6 no err on full window", ecnt - e0, 0);
      if (nb > 8) check(tail_ok, "R5 tail bits high", 32'(tail_ok), 1);
    end else begin
      check(vcnt == v0, "R6 no rx_valid on short window", vcnt - v0, 0);
      check(ecnt - e0 == 1, "R6 err pulse", ecnt - e0, 1);
    end
  endtask

  task automatic async_frame(input logic [7:0] td, input logic tv, input logic [3:0] p,
                             input logic [7:0] rd, input int nb);
    int v0 = vcnt;
    int e0 = ecnt;
    int per = ((rate == 2'b01) ? 16 : 32) * 4;
    logic [7:0] got = 8'h00;
    logic [7:0] exp_tx = prev_tx;
    logic [7:0] exp_rx = prev_rx;
    @(negedge clk);
    txd = td; txv = tv; path = p;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (k == 0) strobe = 1'b1;
      din = (k < 8) ? rd[7-k] : 1'($urandom % 2);
      repeat (per / 2) @(negedge clk);
      if (k < 8) got[7-k] = dout;
      repeat (per - per / 2) @(negedge clk);
    end
    strobe = 1'b0;
    repeat (16) @(negedge clk);
    check(!dout_oe, "R1 async idle", 32'(dout_oe), 0);
    prev_tx = eff_tx(td, tv, p);
    if (nb >= 8) begin
      check(got == exp_tx, "R8/R9 async tx one frame late", got, exp_tx);
      check(vcnt - v0 == 1, "R10 async one rx_valid", vcnt - v0, 1);
      check(vdata == exp_rx, "R8/R7 async rx one frame late", vdata, exp_rx);
      prev_rx = rd;
    end else begin
      check(ecnt - e0 == 1, "R6 async short err", ecnt - e0, 1);
      check(vcnt == v0, "R6 async short no valid", vcnt - v0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(2024);
    do_reset();
    check(!dout_oe && !dout && !rx_valid && !err, "R1 reset state",
          {dout_oe, dout, rx_valid, err}, 0);

    // synchronous directed
    sync_frame(8'hA5, 1'b1, 4'h1, 8'h3C, 8);
    sync_frame(8'h12, 1'b1, 4'h0, 8'h81, 8);   // R4 no path
    sync_frame(8'h34, 1'b1, 4'h9, 8'h7E, 8);   // R4 bit 3 set
    sync_frame(8'h56, 1'b0, 4'h5, 8'h00, 8);   // R4 invalid sample
    sync_frame(8'hC3, 1'b1, 4'h2, 8'hE1, 11);  // R5 long window
    sync_frame(8'h0F, 1'b1, 4'h3, 8'h99, 5);   // R6 short window
    sync_frame(8'h00, 1'b1, 4'h7, 8'hFF, 8);

    // synchronous random
    for (int i = 0; i < 20; i++) begin
      int nb;
      nb = (i % 5 == 3) ? 10 : ((i % 7 == 6) ? 6 : 8);
      sync_frame(8'($urandom), 1'($urandom), 4'($urandom), 8'($urandom), nb);
    end

    // asynchronous, slow rate, external clock left toggling (R9)
    mode = 1'b1; rate = 2'b00; bclk_free = 1'b1;
    do_reset();
    async_frame(8'h5A, 1'b1, 4'h1, 8'h96, 8);
    async_frame(8'hB4, 1'b1, 4'h0, 8'h4B, 8);
    async_frame(8'h21, 1'b1, 4'h6, 8'hD2, 4);   // short, tx store still advances
    async_frame(8'h77, 1'b1, 4'h2, 8'h18, 9);
    async_frame(8'($urandom), 1'b1, 4'h3, 8'($urandom), 8);

    // asynchronous, fast rate (R7)
    rate = 2'b01;
    do_reset();
    for (int i = 0; i < 5; i++)
      async_frame(8'($urandom), 1'($urandom), 4'($urandom), 8'($urandom), 8);

    bclk_free = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule